// File: doc/BRIEF.md
# Five-Stage In-Order Integer Core

This block is a 32-bit in-order integer core for a small load/store subset: word load, word store, register add, register subtract, add-immediate and branch-if-equal. Each instruction moves through five stages: fetch, decode with register read, execute or address calculation, memory access, and write-back. A register sits between each pair of stages, which gives four inter-stage registers. Nothing is registered after write-back, because the register file itself holds the result.

The core drives a synchronous instruction-memory read port and a synchronous data-memory port. Each memory captures its address at a clock edge and returns the data in the following cycle. The core does not forward results between stages. When decode needs a register that an older instruction in execute or memory access has yet to write, the core holds the PC and the fetch/decode register and sends a bubble into execute. A taken branch is resolved in the memory-access stage. It turns the three younger instructions into no-ops and redirects fetch. A debug port reads any architectural register without timing constraints.

Top module: `pipe5_core`

## Requirements
- R1: While reset is asserted, the instruction address is RESET_PC (0 by default), no data-memory write is issued, and every register reads zero. The first instruction fetched after reset is the one at RESET_PC.
- R2: With no hazards, the instruction fetched in cycle 1 after reset writes its result at the end of cycle 5, so the result is readable from cycle 6. Independent instructions complete one per cycle. Instruction k performs its memory access in cycle 4+k, counting k from 0.
- R3: Fields are: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], and the immediate in [15:0]. The opcodes are 0x00 (register form), 0x08 add-immediate, 0x23 load, 0x2B store and 0x04 branch-if-equal. In the register form, funct 0x20 selects add and funct 0x22 selects subtract. The immediate is sign-extended to 32 bits.
- R4: Add and subtract write rd with rs+rt and rs-rt. Add-immediate and load write rt.
- R5: Load and store use the address R[rs] + sext(imm). A store presents R[rt] with the write strobe in its memory-access cycle. A load presents the read strobe in that cycle and takes the returned word in write-back. The write and read strobes are never both high.
- R6: Register 0 always reads zero. Writes to it are discarded, and it never causes a stall.
- R7: A source register that decode reads is a RAW hazard when it matches a non-zero, write-enabled destination held in the decode/execute or execute/memory register. On a hazard, the PC and the fetch/decode register hold, and a bubble enters execute.
- R8: A value being written back can be read by decode in the same cycle. A consumer directly behind its producer therefore waits two cycles, and one with one instruction between them waits one cycle.
- R9: Branch-if-equal compares R[rs] with R[rt] and resolves in the memory-access stage. When not taken, execution continues in order. When taken, fetch moves to (PC+4) + (sext(imm) << 2). The instructions then in fetch/decode, decode/execute and execute/memory are discarded, and none of their stores or register writes take effect.
- R10: The debug port returns the stored value of the register selected by dbg_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address that the instruction memory captures at the next edge |
| imem_rdata | input | 32 | Instruction word for the address captured at the previous edge |
| dmem_addr | output | 32 | Data-memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data for the address captured at the previous edge |
| dbg_addr | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Debug read data |

## Verification
The bench times every store against its expected cycle. Stores that move early show a missing interlock, and stores that move late show extra bubbles or a wrong fill time. The program puts a consumer directly behind its producer, one with a single instruction between them, and a load followed by its user. A core that ignores the write-back bypass would stall one cycle too long. A core that omits a stage comparison would store stale data. A taken branch is followed by two stores and a register write that must all vanish, and a branch that fails the comparison is followed by a store that must appear. A write to register 0 and a negative immediate check that register 0 discards writes and that the immediate is sign-extended.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int XLEN    = 32;
    localparam int REG_AW  = 5;
    localparam int IMM_W   = 16;
    localparam int OP_W    = 6;
    localparam int BYTES_W = XLEN / 8;

    typedef enum logic [OP_W-1:0] {
        OP_REG  = 6'h00,
        OP_BEQ  = 6'h04,
        OP_ADDI = 6'h08,
        OP_LW   = 6'h23,
        OP_SW   = 6'h2B
    } opcode_e;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;

    typedef struct packed {
        logic              wen;
        logic [REG_AW-1:0] dest;
        logic              use_imm;
        logic              sub;
        logic              load;
        logic              store;
        logic              branch;
    } ctrl_t;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] instr;
        logic [XLEN-1:0] pc4;
    } ifid_t;

    typedef struct packed {
        logic            valid;
        ctrl_t           ctl;
        logic [XLEN-1:0] pc4;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] imm;
    } idex_t;

    typedef struct packed {
        logic            valid;
        ctrl_t           ctl;
        logic [XLEN-1:0] alu;
        logic [XLEN-1:0] sdata;
        logic            taken;
        logic [XLEN-1:0] target;
    } exmem_t;

    typedef struct packed {
        logic              valid;
        logic              wen;
        logic [REG_AW-1:0] dest;
        logic              load;
        logic [XLEN-1:0]   alu;
    } memwb_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        ifid_t           ifid;
        idex_t           idex;
        exmem_t          exmem;
        memwb_t          memwb;
    } core_state_t;

endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctl,
    output logic            use_rs,
    output logic            use_rt,
    output logic [XLEN-1:0] imm
);

    opcode_e    op;
    logic [5:0] fn;

    always_comb begin
        op     = opcode_e'(instr[31:26]);
        fn     = instr[5:0];
        imm    = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
        ctl    = '0;
        use_rs = 1'b0;
        use_rt = 1'b0;
        case (op)
            OP_REG: begin
                if (fn == FN_ADD || fn == FN_SUB) begin
                    ctl.wen  = 1'b1;
                    ctl.dest = instr[15:11];
                    ctl.sub  = (fn == FN_SUB);
                    use_rs   = 1'b1;
                    use_rt   = 1'b1;
                end
            end
            OP_ADDI: begin
                ctl.wen     = 1'b1;
                ctl.dest    = instr[20:16];
                ctl.use_imm = 1'b1;
                use_rs      = 1'b1;
            end
            OP_LW: begin
                ctl.wen     = 1'b1;
                ctl.dest    = instr[20:16];
                ctl.use_imm = 1'b1;
                ctl.load    = 1'b1;
                use_rs      = 1'b1;
            end
            OP_SW: begin
                ctl.use_imm = 1'b1;
                ctl.store   = 1'b1;
                use_rs      = 1'b1;
                use_rt      = 1'b1;
            end
            OP_BEQ: begin
                ctl.branch = 1'b1;
                use_rs     = 1'b1;
                use_rt     = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pipe5_hazard.sv
module pipe5_hazard #(
    parameter int N_PROD = 2,
    parameter int RW     = 5
) (
    input  logic                       id_valid,
    input  logic [RW-1:0]              rs,
    input  logic [RW-1:0]              rt,
    input  logic                       use_rs,
    input  logic                       use_rt,
    input  logic [N_PROD-1:0]          prod_wen,
    input  logic [N_PROD-1:0][RW-1:0]  prod_dest,
    output logic                       stall
);

    logic [N_PROD-1:0] hit;

    for (genvar g = 0; g < N_PROD; g++) begin : g_cmp
        assign hit[g] = prod_wen[g] && (prod_dest[g] != '0) &&
                        ((use_rs && prod_dest[g] == rs) ||
                         (use_rt && prod_dest[g] == rt));
    end

    assign stall = id_valid && (|hit);

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
    parameter int AW = 5,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra1,
    output logic [W-1:0]  rd1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd3
);

    localparam int NREG = 1 << AW;

    logic [W-1:0] regs_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we && wa != '0) begin
            regs_q[wa] <= wd;
        end
    end

    // decode ports see the value being written this cycle
    assign rd1 = (ra1 == '0) ? '0 : ((we && wa == ra1) ? wd : regs_q[ra1]);
    assign rd2 = (ra2 == '0) ? '0 : ((we && wa == ra2) ? wd : regs_q[ra2]);
    assign rd3 = (ra3 == '0) ? '0 : regs_q[ra3];

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [XLEN-1:0]   imem_addr,
    input  logic [XLEN-1:0]   imem_rdata,
    output logic [XLEN-1:0]   dmem_addr,
    output logic [XLEN-1:0]   dmem_wdata,
    output logic              dmem_we,
    output logic              dmem_re,
    input  logic [XLEN-1:0]   dmem_rdata,
    input  logic [REG_AW-1:0] dbg_addr,
    output logic [XLEN-1:0]   dbg_data
);

    localparam logic [XLEN-1:0] PC_STEP = XLEN'(BYTES_W);
    localparam int N_PROD = 2;

    core_state_t st_q, st_d;

    ctrl_t             id_ctl;
    logic              id_use_rs, id_use_rt;
    logic [XLEN-1:0]   id_imm, rf_a, rf_b;
    logic [REG_AW-1:0] id_rs, id_rt;
    logic              stall, flush;
    logic              wb_we;
    logic [XLEN-1:0]   wb_data;
    logic [XLEN-1:0]   ex_opb, ex_res;

    assign id_rs = st_q.ifid.instr[25:21];
    assign id_rt = st_q.ifid.instr[20:16];

    pipe5_decode u_dec (
        .instr  (st_q.ifid.instr),
        .ctl    (id_ctl),
        .use_rs (id_use_rs),
        .use_rt (id_use_rt),
        .imm    (id_imm)
    );

    pipe5_hazard #(.N_PROD(N_PROD), .RW(REG_AW)) u_haz (
        .id_valid  (st_q.ifid.valid),
        .rs        (id_rs),
        .rt        (id_rt),
        .use_rs    (id_use_rs),
        .use_rt    (id_use_rt),
        .prod_wen  ({st_q.exmem.valid && st_q.exmem.ctl.wen,
                     st_q.idex.valid  && st_q.idex.ctl.wen}),
        .prod_dest ({st_q.exmem.ctl.dest, st_q.idex.ctl.dest}),
        .stall     (stall)
    );

    assign wb_we   = st_q.memwb.valid && st_q.memwb.wen;
    assign wb_data = st_q.memwb.load ? dmem_rdata : st_q.memwb.alu;

    pipe5_regfile #(.AW(REG_AW), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wb_we),
        .wa    (st_q.memwb.dest),
        .wd    (wb_data),
        .ra1   (id_rs),
        .rd1   (rf_a),
        .ra2   (id_rt),
        .rd2   (rf_b),
        .ra3   (dbg_addr),
        .rd3   (dbg_data)
    );

    // memory-access stage drives the data port
    assign dmem_addr  = st_q.exmem.alu;
    assign dmem_wdata = st_q.exmem.sdata;
    assign dmem_we    = st_q.exmem.valid && st_q.exmem.ctl.store;
    assign dmem_re    = st_q.exmem.valid && st_q.exmem.ctl.load;

    // the instruction memory captures the PC that fetch will hold next cycle
    assign imem_addr = rst_n ? st_d.pc : RESET_PC;

    always_comb begin
        st_d  = st_q;
        flush = st_q.exmem.valid && st_q.exmem.taken;

        // memory access -> write-back
        st_d.memwb.valid = st_q.exmem.valid;
        st_d.memwb.wen   = st_q.exmem.ctl.wen;
        st_d.memwb.dest  = st_q.exmem.ctl.dest;
        st_d.memwb.load  = st_q.exmem.ctl.load;
        st_d.memwb.alu   = st_q.exmem.alu;

        // execute -> memory access
        ex_opb = st_q.idex.ctl.use_imm ? st_q.idex.imm : st_q.idex.b;
        ex_res = st_q.idex.ctl.sub ? (st_q.idex.a - ex_opb) : (st_q.idex.a + ex_opb);
        st_d.exmem.valid  = st_q.idex.valid && !flush;
        st_d.exmem.ctl    = st_q.idex.ctl;
        st_d.exmem.alu    = ex_res;
        st_d.exmem.sdata  = st_q.idex.b;
        st_d.exmem.taken  = st_q.idex.ctl.branch && (st_q.idex.a == st_q.idex.b);
        st_d.exmem.target = st_q.idex.pc4 + {st_q.idex.imm[XLEN-3:0], 2'b00};

        // decode -> execute
        if (stall || flush) begin
            st_d.idex = '0;
        end else begin
            st_d.idex.valid = st_q.ifid.valid;
            st_d.idex.ctl   = id_ctl;
            st_d.idex.pc4   = st_q.ifid.pc4;
            st_d.idex.a     = rf_a;
            st_d.idex.b     = rf_b;
            st_d.idex.imm   = id_imm;
        end

        // fetch -> decode
        if (flush) begin
            st_d.pc   = st_q.exmem.target;
            st_d.ifid = '0;
        end else if (!stall) begin
            st_d.pc         = st_q.pc + PC_STEP;
            st_d.ifid.valid = 1'b1;
            st_d.ifid.instr = imem_rdata;
            st_d.ifid.pc4   = st_q.pc + PC_STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk
    import pipe5_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              dmem_we,
    input logic              dmem_re,
    input logic [REG_AW-1:0] dbg_addr,
    input logic [XLEN-1:0]   dbg_data,
    input logic              stall,
    input logic              flush,
    input logic [XLEN-1:0]   pc_q,
    input logic              ifid_valid,
    input logic              idex_valid,
    input logic              exmem_valid,
    input logic [XLEN-1:0]   br_target
);

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_we && dmem_re));

    assert_zero_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_addr == '0) |-> (dbg_data == '0));

    assert_pc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush) |=> $stable(pc_q));

    assert_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush) |=> !idex_valid);

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !flush) |=> (pc_q == $past(pc_q) + XLEN'(BYTES_W)));

    assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!ifid_valid && !idex_valid && !exmem_valid));

    assert_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (pc_q == $past(br_target)));

endmodule

bind pipe5_core pipe5_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dmem_we     (dmem_we),
    .dmem_re     (dmem_re),
    .dbg_addr    (dbg_addr),
    .dbg_data    (dbg_data),
    .stall       (stall),
    .flush       (flush),
    .pc_q        (st_q.pc),
    .ifid_valid  (st_q.ifid.valid),
    .idex_valid  (st_q.idex.valid),
    .exmem_valid (st_q.exmem.valid),
    .br_target   (st_q.exmem.target)
);

// File: tb/tb_pipe5_core.sv
`timescale 1ns/1ps
module tb_pipe5_core;

    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] imem_addr, imem_rdata;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, dmem_re;
    logic [4:0]  dbg_addr;
    logic [31:0] dbg_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    typedef struct {
        int          cyc;
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } store_exp_t;

    store_exp_t exp_q[$];
    store_exp_t e;

    always #HALF clk = ~clk;

    pipe5_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_re    (dmem_re),
        .dmem_rdata (dmem_rdata),
        .dbg_addr   (dbg_addr),
        .dbg_data   (dbg_data)
    );

    // synchronous memories: address captured at the edge, data next cycle
    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr[7:2]];
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
        dmem_rdata <= dmem[dmem_addr[7:2]];
    end

    // cycle 1 is the first clock period after reset release
    always @(posedge clk) begin
        if (!rst_n) cyc <= 1;
        else        cyc <= cyc + 1;
    end

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push_store(input int c, input logic [31:0] a, input logic [31:0] d,
                              input string tag);
        store_exp_t s;
        s.cyc = c; s.addr = a; s.data = d; s.tag = tag;
        exp_q.push_back(s);
    endtask

    task automatic rd_reg(input int idx, output logic [31:0] v);
        dbg_addr = 5'(idx);
        #1;
        v = dbg_data;
    endtask

    task automatic to_cycle(input int n);
        do @(negedge clk); while (cyc < n);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
    endtask

    // scoreboard monitor: each store is popped and compared as it appears
    always @(negedge clk) begin
        if (rst_n && dmem_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R9 unexpected store: actual addr %h data %h cycle %0d expected no store",
                         dmem_addr, dmem_wdata, cyc);
            end else begin
                e = exp_q.pop_front();
                if (cyc != e.cyc || dmem_addr !== e.addr || dmem_wdata !== e.data) begin
                    fails++;
                    $display("FAIL %s: actual cycle %0d addr %h data %h expected cycle %0d addr %h data %h",
                             e.tag, cyc, dmem_addr, dmem_wdata, e.cyc, e.addr, e.data);
                end
            end
        end
    end

    initial begin
        #(HALF * 2 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n    = 1'b0;
        dbg_addr = '0;
        for (int i = 0; i < 64; i++) begin
            imem[i] = '0;
            dmem[i] = '0;
        end
        imem[0]  = enc_i(6'h08, 5'd0, 5'd1, 16'd5);       // addi r1 = 5
        imem[1]  = enc_i(6'h08, 5'd0, 5'd2, 16'hFFFD);    // addi r2 = -3
        imem[2]  = enc_i(6'h2B, 5'd0, 5'd0, 16'h0040);    // sw r0 -> 0x40
        imem[3]  = enc_i(6'h2B, 5'd0, 5'd0, 16'h0044);    // sw r0 -> 0x44
        imem[4]  = enc_i(6'h08, 5'd0, 5'd0, 16'd9);       // addi r0 (discarded)
        imem[5]  = enc_r(5'd1, 5'd2, 5'd3, 6'h20);        // add r3 = r1 + r2
        imem[6]  = enc_i(6'h2B, 5'd0, 5'd3, 16'h004C);    // sw r3, adjacent use
        imem[7]  = enc_r(5'd2, 5'd1, 5'd4, 6'h22);        // sub r4 = r2 - r1
        imem[8]  = enc_i(6'h08, 5'd0, 5'd5, 16'd1);       // addi r5 = 1
        imem[9]  = enc_i(6'h2B, 5'd0, 5'd4, 16'h0050);    // sw r4, distance 2
        imem[10] = enc_i(6'h23, 5'd0, 5'd6, 16'h004C);    // lw r6 <- 0x4C
        imem[11] = enc_r(5'd6, 5'd6, 5'd7, 6'h20);        // add r7 = r6 + r6
        imem[12] = enc_i(6'h04, 5'd7, 5'd5, 16'd3);       // beq r7, r5 (not taken)
        imem[13] = enc_i(6'h2B, 5'd0, 5'd7, 16'h0054);    // sw r7
        imem[14] = enc_i(6'h04, 5'd5, 5'd5, 16'd3);       // beq r5, r5 -> index 18
        imem[15] = enc_i(6'h2B, 5'd0, 5'd5, 16'h0058);    // flushed
        imem[16] = enc_i(6'h2B, 5'd0, 5'd5, 16'h005C);    // flushed
        imem[17] = enc_i(6'h08, 5'd0, 5'd1, 16'd99);      // flushed
        imem[18] = enc_i(6'h2B, 5'd0, 5'd5, 16'h0060);    // branch target
        imem[19] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);    // branch to self

        push_store(6,  32'h40, 32'h0,        "R2 R5 first store");
        push_store(7,  32'h44, 32'h0,        "R2 back-to-back store");
        push_store(12, 32'h4C, 32'h2,        "R7 R8 R4 adjacent dependence");
        push_store(16, 32'h50, 32'hFFFFFFF8, "R8 R4 distance-two dependence");
        push_store(24, 32'h54, 32'h4,        "R9 not-taken branch falls through");
        push_store(29, 32'h60, 32'h1,        "R9 taken branch target");

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 instruction address in reset", imem_addr, 32'h0);
        chk("R1 no store in reset", {31'b0, dmem_we}, 32'h0);
        rd_reg(3, v);
        chk("R1 register reads zero in reset", v, 32'h0);

        @(posedge clk);
        #2 rst_n = 1'b1;

        to_cycle(5);
        rd_reg(1, v);
        chk("R2 first result not yet written in cycle 5", v, 32'h0);
        to_cycle(6);
        rd_reg(1, v);
        chk("R2 first result visible in cycle 6", v, 32'h5);

        to_cycle(60);
        chk("R9 all expected stores seen, none extra", 32'(exp_q.size()), 32'h0);
        rd_reg(0, v);  chk("R6 register 0 discards write", v, 32'h0);
        rd_reg(1, v);  chk("R9 flushed write to r1 dropped", v, 32'h5);
        rd_reg(2, v);  chk("R3 immediate sign-extended", v, 32'hFFFFFFFD);
        rd_reg(3, v);  chk("R4 add writes rd", v, 32'h2);
        rd_reg(4, v);  chk("R4 sub writes rd", v, 32'hFFFFFFF8);
        rd_reg(5, v);  chk("R10 debug read of r5", v, 32'h1);
        rd_reg(6, v);  chk("R5 load writes rt", v, 32'h2);
        rd_reg(7, v);  chk("R8 load-use result", v, 32'h4);

        summary();
        $finish;
    end

endmodule